// File: doc/BRIEF.md
# ADC Conversion Timing Generator

This block paces an analog-to-digital converter from a fast input clock. A 3-bit code in the timer word selects a power-of-two prescaler from 4 to 128. The prescaler yields a one-cycle core-clock enable. A sample counter then counts a number of core ticks set by a programmable time-unit field, and at the end of each sample period it emits a one-cycle sample strobe.

A global configuration word gates the whole block. The converter runs only while its enable bit is set and both its power-down and clock-down bits are clear. In every other state no ticks or strobes appear, and both counters stay cleared, so each start-up begins a fresh, full-length sample period. Software brings the block up in two steps: it writes the timer word while the block is idle, then writes the configuration word.

Top module: `adc_conv_timer`

## Requirements
- R1: After reset the block is idle. `conv_active`, `core_tick` and `sample_strobe` are all low, and they stay low until the configuration word is written.
- R2: The prescaler code sits in timer word bits 31:29. Codes 0, 1, 2, 3, 4 and 5 give a `core_tick` pulse once every 4, 8, 16, 32, 64 and 128 fast cycles respectively. Each pulse lasts one cycle.
- R3: The reserved prescaler codes 6 and 7 divide by 128.
- R4: The time unit `u` sits in timer word bits UNIT_W-1:0. A sample period spans (u+1)*6 core ticks, so consecutive strobes are div*(u+1)*6 fast cycles apart.
- R5: `sample_strobe` is a one-cycle pulse. It is asserted only in a cycle where `core_tick` is also asserted.
- R6: Configuration word bit 0 is enable, bit 1 is power-down and bit 31 is clock-down. The block runs (`conv_active` high) only when the word has enable=1, power-down=0 and clock-down=0. In every other case there are no ticks or strobes, and both counters are cleared.
- R7: A write to the timer word clears both counters, even while the block runs. The first strobe then follows div*(u+1)*6 cycles after the write edge, using the new settings.
- R8: `wr_sel`=0 addresses the timer word and `wr_sel`=1 the configuration word. Timer word bits UNIT_W through 28 have no effect on the timing.
- R9: Counting from the edge that captures an enabling configuration write, the first `core_tick` is seen div cycles later and the first strobe div*(u+1)*6 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = timer word, 1 = configuration word |
| wr_data | input | 32 | Write data |
| core_tick | output | 1 | Core-clock enable, one fast cycle per core period |
| sample_strobe | output | 1 | One-cycle pulse at the end of each sample period |
| conv_active | output | 1 | High while the configuration word lets the converter run |

## Verification
The hardest case to reach is a timer rewrite that lands part-way through a running sample period. The old count must be abandoned and the new period must be timed from the write edge. The bench starts a run, waits a number of cycles that is not a multiple of the core period, then rewrites the timer word with a different prescaler and unit. It measures the exact distance to the first tick and the first strobe. Reserved prescaler codes and timer words carrying stray middle bits are also exercised, along with random code and unit pairs.

// File: rtl/adc_tmr_pkg.sv
package adc_tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int CODE_HI   = 31;
    localparam int CODE_LO   = 29;
    localparam int EN_BIT    = 0;
    localparam int PWRDN_BIT = 1;
    localparam int CLKDN_BIT = 31;
    localparam int PRE_W     = 7;   // counts up to 127
    localparam int DIV_W     = 8;   // holds 128

    typedef enum logic {
        SEL_TIMER  = 1'b0,
        SEL_GLOBAL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic clk_down;
        logic pwr_down;
        logic enable;
    } glb_cfg_t;

    // Prescale ratio for a 3-bit code; reserved codes fall back to the largest ratio.
    function automatic logic [DIV_W-1:0] div_of(input logic [2:0] code);
        if (code > 3'd5) return DIV_W'(128);
        return DIV_W'(4) << code;
    endfunction

    function automatic logic is_running(input glb_cfg_t c);
        return c.enable & ~c.pwr_down & ~c.clk_down;
    endfunction

endpackage

// File: rtl/adc_tmr_regs.sv
module adc_tmr_regs
    import adc_tmr_pkg::*;
#(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [2:0]        code,
    output logic [UNIT_W-1:0] unit,
    output glb_cfg_t          cfg,
    output logic              timer_wr
);
    assign timer_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_TIMER);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            unit <= '0;
            cfg  <= '{clk_down: 1'b1, pwr_down: 1'b1, enable: 1'b0};
        end else if (wr_en) begin
            if (reg_sel_e'(wr_sel) == SEL_TIMER) begin
                code <= wr_data[CODE_HI:CODE_LO];
                unit <= wr_data[UNIT_W-1:0];
            end else begin
                cfg.clk_down <= wr_data[CLKDN_BIT];
                cfg.pwr_down <= wr_data[PWRDN_BIT];
                cfg.enable   <= wr_data[EN_BIT];
            end
        end
    end
endmodule

// File: rtl/adc_tmr_prescaler.sv
module adc_tmr_prescaler
    import adc_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [PRE_W-1:0] cnt;
    logic [DIV_W-1:0] ratio;
    logic             at_end;

    assign ratio  = div_of(code);
    assign at_end = (cnt == PRE_W'(ratio - DIV_W'(1)));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + PRE_W'(1);
    end
endmodule

// File: rtl/adc_tmr_sampler.sv
module adc_tmr_sampler #(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              tick,
    input  logic [UNIT_W-1:0] unit,
    output logic              strobe
);
    localparam int CNT_W = $clog2((2 ** UNIT_W) * 6);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             at_end;

    // last index of a period of (unit+1)*6 ticks
    assign limit  = CNT_W'(unit) * CNT_W'(6) + CNT_W'(5);
    assign at_end = (cnt == limit);
    assign strobe = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (tick)
            cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_tmr_pkg::*;
#(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              core_tick,
    output logic              sample_strobe,
    output logic              conv_active
);
    logic [2:0]        code;
    logic [UNIT_W-1:0] unit;
    glb_cfg_t          cfg;
    logic              timer_wr;
    logic              hold;

    adc_tmr_regs #(.UNIT_W(UNIT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .code     (code),
        .unit     (unit),
        .cfg      (cfg),
        .timer_wr (timer_wr)
    );

    assign conv_active = is_running(cfg);
    assign hold        = timer_wr || !conv_active;

    adc_tmr_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (hold),
        .run   (conv_active),
        .code  (code),
        .tick  (core_tick)
    );

    adc_tmr_sampler #(.UNIT_W(UNIT_W)) u_smp (
        .clk    (clk),
        .rst    (rst),
        .clear  (hold),
        .tick   (core_tick),
        .unit   (unit),
        .strobe (sample_strobe)
    );
endmodule

// File: rtl/adc_tmr_checker.sv
module adc_tmr_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic wr_sel,
    input logic conv_active,
    input logic core_tick,
    input logic sample_strobe
);
    p_strobe_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> core_tick);

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        core_tick |=> !core_tick);

    p_gate_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !conv_active |-> !core_tick);

    p_gate_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        !conv_active |-> !sample_strobe);

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> !core_tick);

    p_idle_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !conv_active);
endmodule

bind adc_conv_timer adc_tmr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .conv_active   (conv_active),
    .core_tick     (core_tick),
    .sample_strobe (sample_strobe)
);

// File: tb/adc_conv_timer_bench.sv
module adc_conv_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        core_tick;
    logic        sample_strobe;
    logic        conv_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    adc_conv_timer #(.UNIT_W(8)) u_adc_conv_timer (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .core_tick     (core_tick),
        .sample_strobe (sample_strobe),
        .conv_active   (conv_active)
    );

    function automatic int exp_div(input int code);
        if (code >= 6) return 128;
        return 4 << code;
    endfunction

    function automatic logic [31:0] timer_word(input int code, input int u, input logic [31:0] junk);
        return (32'(code) << 29) | (junk & 32'h1FFF_FF00) | 32'(u & 8'hFF);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives a write on a falling edge; returns on the falling edge after the capture edge.
    task automatic write_reg(input logic sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Observe two sample periods; index 1 is the falling edge after the restart edge.
    task automatic observe(input int div, input int u, input string req);
        int p = (u + 1) * 6;
        int span = div * p;
        int first_tick = 0, first_str = 0, second_str = 0, n_str = 0, n_tick = 0;
        bit orphan = 0;
        for (int n = 1; n <= 2 * span; n++) begin
            if (n > 1) @(negedge clk);
            if (core_tick) begin
                n_tick++;
                if (first_tick == 0) first_tick = n;
            end
            if (sample_strobe) begin
                n_str++;
                if (!core_tick) orphan = 1;
                if (first_str == 0) first_str = n;
                else if (second_str == 0) second_str = n;
            end
        end
        check(first_tick == div, {req, " R9 first tick"}, first_tick, div);
        check(first_str == span, {req, " R9 first strobe"}, first_str, span);
        check(second_str == 2 * span, {req, " R4 strobe spacing"}, second_str, 2 * span);
        check(n_tick == 2 * p, {req, " R2 tick count"}, n_tick, 2 * p);
        check(n_str == 2 && !orphan, {req, " R5 strobe pulses"}, n_str, 2);
    endtask

    task automatic run_case(input int code, input int u, input logic [31:0] junk, input string req);
        write_reg(1'b1, 32'h0);
        write_reg(1'b0, timer_word(code, u, junk));
        write_reg(1'b1, 32'h0000_0001);
        observe(exp_div(code), u, req);
    endtask

    task automatic quiet(input logic [31:0] cfg_word, input string req);
        int seen = 0;
        write_reg(1'b1, cfg_word);
        for (int n = 0; n < 600; n++) begin
            if (n > 0) @(negedge clk);
            if (core_tick || sample_strobe || conv_active) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset
        seen = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (core_tick || sample_strobe || conv_active) seen++;
        end
        check(seen == 0, "R1 idle after reset", seen, 0);
        write_reg(1'b0, timer_word(0, 0, 32'h0));
        quiet(32'h8000_0002, "R1 timer write alone stays idle");

        // R2: every legal prescaler code
        for (int c = 0; c < 6; c++) run_case(c, 0, 32'h0, "R2 code");
        // R3: reserved codes
        run_case(6, 1, 32'h0, "R3 code6");
        run_case(7, 0, 32'h0, "R3 code7");
        // R4: several units
        run_case(0, 3, 32'h0, "R4 unit3");
        run_case(1, 7, 32'h0, "R4 unit7");
        // R8: stray middle bits ignored
        run_case(0, 2, 32'h1FFF_FF00, "R8 junk bits");

        // R6: each gating bit alone holds the block
        quiet(32'h0000_0003, "R6 power-down");
        quiet(32'h8000_0001, "R6 clock-down");
        quiet(32'h0000_0000, "R6 enable clear");
        quiet(32'h8000_0002, "R6 all gated");
        // R6: re-enable after running starts a full period
        run_case(1, 1, 32'h0, "R6 re-enable");

        // R7: timer rewrite mid-period while running
        write_reg(1'b1, 32'h0);
        write_reg(1'b0, timer_word(0, 2, 32'h0));
        write_reg(1'b1, 32'h1);
        repeat (29) @(negedge clk);
        write_reg(1'b0, timer_word(1, 0, 32'h0));
        check(conv_active == 1'b1, "R7 still active", conv_active, 1);
        observe(8, 0, "R7 restart");

        // random pairs (R2 R3 R4)
        for (int i = 0; i < 6; i++) begin
            int c = int'($urandom % 8);
            int u = int'($urandom % 4);
            run_case(c, u, $urandom, "R4 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule